// File: doc/BRIEF.md
# Qualified Bus Wake-Up Detector

This block watches the received level of a single-wire vehicle bus while a node sits in its low-power state. It raises a one-clock wake pulse when that level shows a genuine remote wake request. It also raises the pulse on a falling edge of a local, active-low wake pin. Both inputs are asynchronous, so each one passes through its own two-flop synchroniser. A counter times how long the bus stays low, and it advances only on a one-microsecond tick from elsewhere in the chip. The surrounding mode controller drives `sleep_en` high only while the node is in the low-power state.

A parameter selects one of two qualification rules. Under the edge-then-low rule, the bus must fall from high to low and then stay low for the debounce time. Under the low-then-rise rule, the bus must stay low for the debounce time, and the wake is declared on the rising edge that follows. The second rule stops a bus that has lost its pull-ups, and has drifted low, from waking every node on it. Once a wake has been reported, no further wake is reported until `sleep_en` has been low and then high again.

Top module: `wake_detect`

## Requirements
- R1: After a synchronous reset, `wake_pulse` is 0. The synchronisers reset to the idle-high level, so the release of reset causes no edge.
- R2: `bus_rx` and `wake_pin_n` each pass through two flops before use. `wake_pulse` is registered and rises one clock after the qualifying condition appears on the synchronised level.
- R3: With `RULE` = 0 (edge-then-low), a high-to-low bus transition followed by `DEB_TICKS` ticks of continuous low produces one wake pulse while the bus is still low.
- R4: With `RULE` = 0, a bus that is already low when `sleep_en` rises has had no falling edge, so it does not wake the node however long it stays low.
- R5: With `RULE` = 1 (low-then-rise), a low lasting at least `DEB_TICKS` ticks produces no wake while it lasts. The wake pulse follows the first high level after that low.
- R6: A low that ends before `DEB_TICKS` ticks produces no wake under either rule, and its count is discarded. Several short lows never add up to one long low.
- R7: A high-to-low transition of `wake_pin_n` produces a wake pulse under either rule.
- R8: While `sleep_en` is 0, no bus or pin activity produces a wake pulse.
- R9: Each wake pulse lasts exactly one clock. After a pulse, no further pulse occurs until `sleep_en` has gone low and then high again.
- R10: The low-time counter saturates at `DEB_TICKS`. A low many times longer than the counter range still qualifies under the low-then-rise rule when it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-clock strobe every microsecond; advances the low-time counter |
| sleep_en | input | 1 | High only while the node is in the low-power state |
| bus_rx | input | 1 | Asynchronous received bus level, 1 = recessive (high) |
| wake_pin_n | input | 1 | Asynchronous local wake pin, idle high, active on its falling edge |
| wake_pulse | output | 1 | Registered one-clock wake indication |

## Verification
The hardest case to reach is a low that outlasts the counter's whole binary range and then ends, because a counter that wraps gives the wrong result here. The bench reaches it by holding the bus low for more than a hundred ticks before releasing it. Two other cases also need care. The first is a bus that was already low before the enable rose. The second is a series of short lows whose combined length exceeds the debounce time. To produce both, the bench orders changes on `sleep_en` and `bus_rx` around each other. Both qualification rules are instantiated side by side, so one stimulus stream shows where the two rules differ.

// File: rtl/wkdet_pkg.sv
package wkdet_pkg;
  typedef enum logic {
    RULE_EDGE_THEN_LOW = 1'b0,
    RULE_LOW_THEN_RISE = 1'b1
  } wake_rule_e;
endpackage

// File: rtl/wkdet_sync.sv
module wkdet_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[gi] <= RST_VAL;
        else if (gi == 0) stage_q[gi] <= d;
        else stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wkdet_bus_qual.sv
module wkdet_bus_qual
  import wkdet_pkg::*;
#(
  parameter wake_rule_e RULE      = RULE_EDGE_THEN_LOW,
  parameter int         DEB_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  input  logic bus_s,
  output logic req
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] THR = CW'(DEB_TICKS);

  logic          bus_d;
  logic          seen_fall;
  logic [CW-1:0] low_cnt;
  logic          at_thr;
  logic          count_ok;

  assign at_thr = (low_cnt == THR);

  generate
    if (RULE == RULE_EDGE_THEN_LOW) begin : g_edge_low
      assign count_ok = seen_fall;
      assign req      = en && seen_fall && !bus_s && at_thr;
    end else begin : g_low_rise
      assign count_ok = 1'b1;
      assign req      = en && bus_s && !bus_d && at_thr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_d     <= 1'b1;
      seen_fall <= 1'b0;
      low_cnt   <= '0;
    end else begin
      bus_d     <= bus_s;
      seen_fall <= en && !bus_s && (seen_fall || bus_d);
      if (!en || bus_s)
        low_cnt <= '0;
      else if (count_ok && tick && !at_thr)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (at_thr && en && !bus_s) |=> at_thr);

  // R6
  low_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_s || !en) |=> (low_cnt == '0));
endmodule

// File: rtl/wkdet_pin_edge.sv
module wkdet_pin_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pin_s,
  output logic req
);
  logic pin_d;

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b1;
    else     pin_d <= pin_s;
  end

  assign req = en && pin_d && !pin_s;

  // R7
  pin_fall_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> ($past(pin_s) && !pin_s));
endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import wkdet_pkg::*;
#(
  parameter wake_rule_e RULE        = RULE_EDGE_THEN_LOW,
  parameter int         DEB_TICKS   = 20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic sleep_en,
  input  logic bus_rx,
  input  logic wake_pin_n,
  output logic wake_pulse
);
  logic [1:0] raw_in;
  logic [1:0] sync_q;
  logic       bus_req;
  logic       pin_req;
  logic       any_req;
  logic       reported;

  assign raw_in = {bus_rx, wake_pin_n};

  wkdet_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_q)
  );

  wkdet_bus_qual #(.RULE(RULE), .DEB_TICKS(DEB_TICKS)) bus_qual_i (
    .clk(clk), .rst(rst), .tick(tick_us), .en(sleep_en),
    .bus_s(sync_q[1]), .req(bus_req)
  );

  wkdet_pin_edge pin_edge_i (
    .clk(clk), .rst(rst), .en(sleep_en), .pin_s(sync_q[0]), .req(pin_req)
  );

  assign any_req = bus_req || pin_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      reported   <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= sleep_en && any_req && !reported;
      reported   <= sleep_en && (reported || any_req);
    end
  end

  // R9
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  // R8
  sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep_en |=> !wake_pulse);

  // R9
  no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (reported && sleep_en) |=> !wake_pulse);
endmodule

// File: tb/wake_detect_tb.sv
module wake_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEB        = 8;
  localparam int TICK_DIV   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0;
  logic sleep_en = 1'b0;
  logic bus_rx = 1'b1;
  logic wake_pin_n = 1'b1;
  logic pulse_f, pulse_r;

  int checks = 0;
  int failures = 0;
  int n_f = 0, n_r = 0;
  int tick_div = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_detect #(.RULE(wkdet_pkg::RULE_EDGE_THEN_LOW), .DEB_TICKS(DEB)) dut_i (
    .clk(clk), .rst(rst), .tick_us(tick_us), .sleep_en(sleep_en),
    .bus_rx(bus_rx), .wake_pin_n(wake_pin_n), .wake_pulse(pulse_f));

  wake_detect #(.RULE(wkdet_pkg::RULE_LOW_THEN_RISE), .DEB_TICKS(DEB)) dut_rise_i (
    .clk(clk), .rst(rst), .tick_us(tick_us), .sleep_en(sleep_en),
    .bus_rx(bus_rx), .wake_pin_n(wake_pin_n), .wake_pulse(pulse_r));

  // behavioural reference, one lane per rule (0 = edge-then-low, 1 = low-then-rise)
  bit b1, b2, bd, p1, p2, pd;
  int m_cnt [2];
  bit m_sf [2], m_done [2], m_pulse [2];

  always @(posedge clk) begin
    if (rst) begin
      b1 = 1; b2 = 1; bd = 1; p1 = 1; p2 = 1; pd = 1;
      for (int r = 0; r < 2; r++) begin
        m_cnt[r] = 0; m_sf[r] = 0; m_done[r] = 0; m_pulse[r] = 0;
      end
    end else begin
      for (int r = 0; r < 2; r++) begin
        bit full, rb, rp, rq;
        full = (m_cnt[r] >= DEB);
        rb = (r == 0) ? (sleep_en && m_sf[r] && !b2 && full)
                      : (sleep_en && b2 && !bd && full);
        rp = sleep_en && pd && !p2;
        rq = rb || rp;
        m_pulse[r] = sleep_en && rq && !m_done[r];
        m_done[r]  = sleep_en && (m_done[r] || rq);
        if (!sleep_en || b2) m_cnt[r] = 0;
        else if ((r == 1 || m_sf[r]) && tick_us && !full) m_cnt[r] = m_cnt[r] + 1;
        m_sf[r] = sleep_en && !b2 && (m_sf[r] || bd);
      end
      bd = b2; b2 = b1; b1 = bus_rx;
      pd = p2; p2 = p1; p1 = wake_pin_n;
    end
  end

  // per-cycle comparison and pulse counting, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      checks++;
      if (pulse_f !== m_pulse[0] || pulse_r !== m_pulse[1]) begin
        failures++;
        $display("FAIL R2 cycle model: actual f=%0b r=%0b expected f=%0b r=%0b",
                 pulse_f, pulse_r, m_pulse[0], m_pulse[1]);
      end
      if (pulse_f) n_f++;
      if (pulse_r) n_r++;
    end
    tick_div = (tick_div + 1) % TICK_DIV;
    tick_us <= (tick_div == 0);
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_cnt(input string req, input int ef, input int er);
    checks++;
    if (n_f != ef || n_r != er) begin
      failures++;
      $display("FAIL %s: actual f=%0d r=%0d expected f=%0d r=%0d", req, n_f, n_r, ef, er);
    end
    n_f = 0; n_r = 0;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait_cyc(5);
    // R1: reset state
    checks++;
    if (pulse_f !== 1'b0 || pulse_r !== 1'b0) begin
      failures++;
      $display("FAIL R1: actual f=%0b r=%0b expected 0 0", pulse_f, pulse_r);
    end
    rst = 1'b0;
    wait_cyc(5);
    expect_cnt("R1 release", 0, 0);

    // R3 / R5: long low then release
    sleep_en = 1; wait_cyc(5);
    bus_rx = 0; wait_cyc(60);
    expect_cnt("R3 R5 during low", 1, 0);
    bus_rx = 1; wait_cyc(6);
    expect_cnt("R5 rise", 0, 1);
    sleep_en = 0; wait_cyc(4);

    // R6: two short lows that together exceed the threshold
    sleep_en = 1; wait_cyc(4);
    bus_rx = 0; wait_cyc(18); bus_rx = 1; wait_cyc(6);
    bus_rx = 0; wait_cyc(18); bus_rx = 1; wait_cyc(6);
    expect_cnt("R6 short lows", 0, 0);
    sleep_en = 0; wait_cyc(4);

    // R8: activity while not in low-power state
    bus_rx = 0; wait_cyc(60); bus_rx = 1; wait_cyc(6);
    wake_pin_n = 0; wait_cyc(5); wake_pin_n = 1; wait_cyc(6);
    expect_cnt("R8 disabled", 0, 0);

    // R4 / R5: bus already low when enabled
    bus_rx = 0; wait_cyc(10);
    sleep_en = 1; wait_cyc(60);
    expect_cnt("R4 pre-low", 0, 0);
    bus_rx = 1; wait_cyc(6);
    expect_cnt("R5 pre-low rise", 0, 1);
    sleep_en = 0; wait_cyc(4);

    // R7 / R9: pin wake, no repeat, re-arm
    sleep_en = 1; wait_cyc(4);
    wake_pin_n = 0; wait_cyc(5); wake_pin_n = 1; wait_cyc(5);
    expect_cnt("R7 pin wake", 1, 1);
    bus_rx = 0; wait_cyc(60); bus_rx = 1; wait_cyc(6);
    wake_pin_n = 0; wait_cyc(5); wake_pin_n = 1; wait_cyc(5);
    expect_cnt("R9 no repeat", 0, 0);
    sleep_en = 0; wait_cyc(3); sleep_en = 1; wait_cyc(3);
    wake_pin_n = 0; wait_cyc(5); wake_pin_n = 1; wait_cyc(5);
    expect_cnt("R9 rearm", 1, 1);
    sleep_en = 0; wait_cyc(4);

    // R10: very long low, far beyond counter range
    sleep_en = 1; wait_cyc(4);
    bus_rx = 0; wait_cyc(400);
    expect_cnt("R3 long low", 1, 0);
    bus_rx = 1; wait_cyc(6);
    expect_cnt("R10 saturation", 0, 1);
    sleep_en = 0; wait_cyc(4);

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule